// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Bus Cycle Generator

This block runs one programmed-I/O bus cycle at a time on a parallel ATA (True IDE) port. An internal queue gives it a request: the direction, a register select and the write data. The block then drives the two chip selects, the three-bit register address, the read and write strobes and the data-bus output enable. On a read it samples the drive's data bus. Two kinds of register can be reached. The data register moves 16 bits. Every other task-file or control-block register moves only the low byte.

Each cycle has three phases: address setup, strobe active and recovery. A packed timing word sets the length of each phase in controller clock cycles. When the IORDY stretch is switched on, a drive can hold the active phase open by keeping IORDY low, up to a fixed limit. If the limit is reached, the cycle ends and an error flag is set. A byte-order option swaps the two halves of every data-register transfer. No cycle starts while the interface enable is low. A one-cycle done pulse marks the end of each cycle, and the next request is accepted only after it.

Top module: `pata_pio_cycle`

## Requirements
- R1: The setup length comes from `timing_word[3:0]`, the active length from `timing_word[11:4]` and the recovery length from `timing_word[19:12]`, all in clock cycles. Setup is the number of cycles the chip select is asserted before a strobe. Active is the number of cycles the strobe is low. Recovery is the number of cycles from strobe release up to the done pulse.
- R2: A timing field that holds zero gives a phase of one cycle.
- R3: `req_sel[3]` clear selects the command block (`ata_cs_n` = 2'b10) and `req_sel[3]` set selects the control block (`ata_cs_n` = 2'b01). `ata_addr` equals `req_sel[2:0]`. Chip select and address stay constant from the first setup cycle to the last active cycle. `ata_cs_n` is 2'b11 during recovery and idle.
- R4: With `cfg_iordy_en` low, the active phase has exactly its programmed length, whatever the level of IORDY.
- R5: With `cfg_iordy_en` high and IORDY low in the last programmed active cycle, the strobe stays low. Once IORDY is sampled high at a rising edge, the strobe is released at the third rising edge, counting that edge as the first (two-stage synchronizer).
- R6: The stretch lasts at most 256 cycles beyond the programmed active length. At that point the strobe ends anyway and `timeout_err` goes high. The flag stays high until the next request is accepted, which clears it.
- R7: On a write, `ata_doe` is high from the first setup cycle to the last recovery cycle and low at all other times. A read never drives the bus. A write to the data register (`req_sel` = 4'b0000) drives all 16 bits. Any other register gets the low byte with the upper byte zero.
- R8: On a read, `rd_data` takes `ata_din` at the edge that releases the strobe and holds it until the next read. For any register other than the data register, the upper byte of `rd_data` is zero.
- R9: With `cfg_swap` high, the two bytes of each data-register transfer are exchanged, in both directions. `cfg_swap` has no effect on task-file transfers.
- R10: While `ctl_enable` is low, `req_ready` is low and no cycle starts, even when a request is pending.
- R11: `done` is high for exactly one cycle: the first cycle after recovery. This is setup+active+recovery+1 cycles after the accepting edge. `req_ready` is high only when the block is idle and enabled.
- R12: After reset, `ata_cs_n` is 2'b11, both strobes are high, and `ata_doe`, `done`, `timeout_err` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Interface enable (control bit 0) |
| cfg_iordy_en | input | 1 | IORDY stretch enable (configuration bit 1) |
| cfg_swap | input | 1 | Data-register byte swap (configuration bit 6) |
| timing_word | input | 20 | Packed setup, active and recovery counts |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 4 | Bit 3 = control block, bits 2:0 = register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rd_data | output | 16 | Captured read data |
| timeout_err | output | 1 | IORDY stretch hit its limit |
| ata_cs_n | output | 2 | Active-low chip selects (bit 0 command, bit 1 control) |
| ata_addr | output | 3 | Register address |
| ata_dior_n | output | 1 | Active-low read strobe |
| ata_diow_n | output | 1 | Active-low write strobe |
| ata_dout | output | 16 | Data bus output value |
| ata_doe | output | 1 | Data bus output enable |
| ata_din | input | 16 | Data bus input value |
| ata_iordy | input | 1 | Drive ready (asynchronous) |

## Verification
Every phase follows the edge that accepts the request. Setup covers the next S cycles, active the A cycles after that, and recovery the R cycles after that. `done` is then high in cycle S+A+R+1, and `rd_data` is valid from that same cycle. The bench samples on falling edges and counts those cycles by how the chip select, the strobes and the output enable look. It compares the counts against the fields it programmed. For a stretch, it raises IORDY on a known falling edge and expects the strobe to end two cycles after the cycle in which it did so, which is 257 active cycles when IORDY stays low with an active length of one.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;

  // active-low chip-select codes: bit 0 command block, bit 1 control block
  localparam logic [1:0] CS_NONE = 2'b11;
  localparam logic [1:0] CS_CMD  = 2'b10;
  localparam logic [1:0] CS_CTL  = 2'b01;

endpackage

// File: rtl/pata_pio_sync.sv
module pata_pio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pata_pio_timing.sv
module pata_pio_timing #(
  parameter int SU_W  = 4,
  parameter int ACT_W = 8,
  parameter int REC_W = 8,
  parameter int CNT_W = 8,
  parameter int TW    = SU_W + ACT_W + REC_W
) (
  input  logic [TW-1:0]    timing_word,
  output logic [CNT_W-1:0] su_last,
  output logic [CNT_W-1:0] act_last,
  output logic [CNT_W-1:0] rec_last
);

  localparam int ACT_LSB = SU_W;
  localparam int REC_LSB = SU_W + ACT_W;

  // last counter value of a phase; zero and one both give a single cycle
  function automatic logic [CNT_W-1:0] last_of(input logic [CNT_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  assign su_last  = last_of(CNT_W'(timing_word[SU_W-1:0]));
  assign act_last = last_of(CNT_W'(timing_word[ACT_LSB +: ACT_W]));
  assign rec_last = last_of(CNT_W'(timing_word[REC_LSB +: REC_W]));

endmodule

// File: rtl/pata_pio_fmt.sv
module pata_pio_fmt #(
  parameter int DW = 16
) (
  input  logic          wide,
  input  logic          swap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int HW = DW / 2;

  always_comb begin
    if (!wide)     dout = {{(DW-HW){1'b0}}, din[HW-1:0]};
    else if (swap) dout = {din[HW-1:0], din[DW-1:HW]};
    else           dout = din;
  end

endmodule

// File: rtl/pata_pio_cycle.sv
module pata_pio_cycle #(
  parameter int SU_W        = 4,
  parameter int ACT_W       = 8,
  parameter int REC_W       = 8,
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int WAIT_LIMIT  = 256,
  parameter int SYNC_STAGES = 2,
  parameter int TW          = SU_W + ACT_W + REC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_enable,
  input  logic          cfg_iordy_en,
  input  logic          cfg_swap,
  input  logic [TW-1:0] timing_word,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW:0]   req_sel,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          timeout_err,
  output logic [1:0]    ata_cs_n,
  output logic [AW-1:0] ata_addr,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [DW-1:0] ata_dout,
  output logic          ata_doe,
  input  logic [DW-1:0] ata_din,
  input  logic          ata_iordy
);
  import pata_pio_pkg::*;

  localparam int MAXF   = (SU_W > ACT_W) ? ((SU_W > REC_W) ? SU_W : REC_W)
                                         : ((ACT_W > REC_W) ? ACT_W : REC_W);
  localparam int CNT_W  = MAXF;
  localparam int WCNT_W = $clog2(WAIT_LIMIT + 1);

  pio_phase_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WCNT_W-1:0] wait_q, wait_d;
  logic              accept, capture, done_d, err_set;
  logic              wr_q, wide_q, swap_q, iordy_en_q, ctl_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic              err_q, done_q;
  logic              iordy_s;
  logic [CNT_W-1:0]  su_last, act_last, rec_last;
  logic [DW-1:0]     wfmt, rfmt;
  logic              req_wide;

  assign req_wide = !req_sel[AW] && (req_sel[AW-1:0] == '0);

  pata_pio_timing #(.SU_W(SU_W), .ACT_W(ACT_W), .REC_W(REC_W), .CNT_W(CNT_W), .TW(TW))
    u_timing (.timing_word(timing_word), .su_last(su_last),
              .act_last(act_last), .rec_last(rec_last));

  pata_pio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1))
    u_iordy_sync (.clk(clk), .rst_n(rst_n), .d(ata_iordy), .q(iordy_s));

  pata_pio_fmt #(.DW(DW)) u_wfmt (.wide(req_wide), .swap(cfg_swap),
                                  .din(req_wdata), .dout(wfmt));
  pata_pio_fmt #(.DW(DW)) u_rfmt (.wide(wide_q), .swap(swap_q),
                                  .din(ata_din), .dout(rfmt));

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    wait_d  = wait_q;
    accept  = 1'b0;
    capture = 1'b0;
    done_d  = 1'b0;
    err_set = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (ctl_enable && req_valid) begin
          accept = 1'b1;
          st_d   = PH_SETUP;
          cnt_d  = su_last;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          st_d   = PH_ACTIVE;
          cnt_d  = act_last;
          wait_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (iordy_en_q && !iordy_s && (wait_q != WCNT_W'(WAIT_LIMIT))) begin
          wait_d = wait_q + 1'b1;
        end else begin
          err_set = iordy_en_q && !iordy_s;
          capture = !wr_q;
          st_d    = PH_RECOV;
          cnt_d   = rec_last;
        end
      end
      PH_RECOV: begin
        if (cnt_q == '0) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
      done_q <= done_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= 1'b0;
      wide_q     <= 1'b0;
      swap_q     <= 1'b0;
      iordy_en_q <= 1'b0;
      ctl_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else if (accept) begin
      wr_q       <= req_write;
      wide_q     <= req_wide;
      swap_q     <= cfg_swap;
      iordy_en_q <= cfg_iordy_en;
      ctl_q      <= req_sel[AW];
      addr_q     <= req_sel[AW-1:0];
      wdata_q    <= wfmt;
    end
  end

  // read data, enabled on strobe release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rfmt;
  end

  // sticky stretch timeout, cleared by the next accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (accept)  err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  // outputs
  assign req_ready   = (st_q == PH_IDLE) && ctl_enable;
  assign ata_cs_n    = ((st_q == PH_SETUP) || (st_q == PH_ACTIVE))
                       ? (ctl_q ? CS_CTL : CS_CMD) : CS_NONE;
  assign ata_addr    = addr_q;
  assign ata_dior_n  = !((st_q == PH_ACTIVE) && !wr_q);
  assign ata_diow_n  = !((st_q == PH_ACTIVE) && wr_q);
  assign ata_doe     = wr_q && (st_q != PH_IDLE);
  assign ata_dout    = wdata_q;
  assign done        = done_q;
  assign rd_data     = rdata_q;
  assign timeout_err = err_q;

endmodule

// File: rtl/pata_pio_cycle_chk.sv
module pata_pio_cycle_chk #(
  parameter int AW         = 3,
  parameter int ACT_W      = 8,
  parameter int WAIT_LIMIT = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_enable,
  input logic [1:0]    phase,
  input logic [1:0]    ata_cs_n,
  input logic [AW-1:0] ata_addr,
  input logic          ata_dior_n,
  input logic          ata_diow_n,
  input logic          ata_doe,
  input logic          done
);
  import pata_pio_pkg::*;

  localparam int MAX_ACT = (1 << ACT_W) - 1 + WAIT_LIMIT;
  localparam int RUN_W   = $clog2(MAX_ACT + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        run_q <= '0;
    else if (!ata_dior_n || !ata_diow_n) run_q <= run_q + 1'b1;
    else                               run_q <= '0;
  end

  // R3
  cs_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ata_cs_n != CS_NONE && $past(ata_cs_n) != CS_NONE) |-> ($stable(ata_cs_n) && $stable(ata_addr)));

  // R3
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (ata_cs_n != CS_NONE));

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ata_doe |-> ata_dior_n);

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enable && phase == PH_IDLE) |=> (phase == PH_IDLE));

  // R6
  active_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(MAX_ACT));

endmodule

bind pata_pio_cycle pata_pio_cycle_chk #(.AW(AW), .ACT_W(ACT_W), .WAIT_LIMIT(WAIT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .phase(st_q),
  .ata_cs_n(ata_cs_n), .ata_addr(ata_addr), .ata_dior_n(ata_dior_n),
  .ata_diow_n(ata_diow_n), .ata_doe(ata_doe), .done(done)
);

// File: tb/pata_pio_cycle_bench.sv
`timescale 1ns/1ps
module pata_pio_cycle_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_enable, cfg_iordy_en, cfg_swap;
  logic [19:0] timing_word;
  logic        req_valid, req_ready, req_write;
  logic [3:0]  req_sel;
  logic [15:0] req_wdata;
  logic        done, timeout_err;
  logic [15:0] rd_data;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_addr;
  logic        ata_dior_n, ata_diow_n, ata_doe;
  logic [15:0] ata_dout, ata_din;
  logic        ata_iordy;

  always #2.5 clk = ~clk;

  pata_pio_cycle u_pata_pio_cycle (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .cfg_iordy_en(cfg_iordy_en),
    .cfg_swap(cfg_swap), .timing_word(timing_word), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_sel(req_sel),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .timeout_err(timeout_err),
    .ata_cs_n(ata_cs_n), .ata_addr(ata_addr), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dout(ata_dout), .ata_doe(ata_doe),
    .ata_din(ata_din), .ata_iordy(ata_iordy)
  );

  int n_chk = 0, n_fail = 0;
  int wd = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk("watchdog", 32'd1, 32'd0);
      finish_run();
    end
  end

  // falling-edge monitor: phase lengths and bus values per cycle
  int c_su, c_act, c_rec, c_doe, r_su, r_act, r_rec, r_doe;
  logic seen_act;
  logic [1:0] r_cs;
  logic [2:0] r_addr;
  logic [15:0] r_dout;
  bit bad_ready;

  always @(negedge clk) begin
    if (!rst_n) begin
      c_su = 0; c_act = 0; c_rec = 0; c_doe = 0; seen_act = 0; bad_ready = 0;
    end else if (done) begin
      r_su = c_su; r_act = c_act; r_rec = c_rec; r_doe = c_doe;
      c_su = 0; c_act = 0; c_rec = 0; c_doe = 0; seen_act = 0;
    end else begin
      if (ata_doe) c_doe++;
      if (!ata_dior_n || !ata_diow_n) begin
        c_act++; seen_act = 1; r_cs = ata_cs_n; r_addr = ata_addr; r_dout = ata_dout;
      end else if (ata_cs_n != 2'b11 && !seen_act) c_su++;
      else if (seen_act) c_rec++;
      if (req_ready && (ata_cs_n != 2'b11 || seen_act)) bad_ready = 1;
    end
  end

  function automatic logic [19:0] tw(input int s, input int a, input int r);
    return {r[7:0], a[7:0], s[3:0]};
  endfunction

  int n_to_done;

  task automatic start_req(input logic wr, input logic [3:0] sel, input logic [15:0] wd_in,
                           input logic [19:0] t);
    @(negedge clk);
    timing_word = t; req_write = wr; req_sel = sel; req_wdata = wd_in; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    n_to_done = 1;
    while (!done) begin @(negedge clk); n_to_done++; end
    #1;
  endtask

  task automatic run(input logic wr, input logic [3:0] sel, input logic [15:0] wd_in,
                     input logic [19:0] t);
    start_req(wr, sel, wd_in, t);
    wait_done();
  endtask

  task automatic t_reset();
    chk("R12 cs_n", ata_cs_n, 2'b11);
    chk("R12 strobes", {ata_dior_n, ata_diow_n}, 2'b11);
    chk("R12 doe/done/err", {ata_doe, done, timeout_err}, 3'b000);
    chk("R12 rd_data", rd_data, 16'h0);
    chk("R10 ready while disabled", req_ready, 1'b0);
  endtask

  task automatic t_timing();
    run(1'b1, 4'h2, 16'h77A5, tw(3, 5, 4));
    chk("R1 setup 3", r_su, 3); chk("R1 active 5", r_act, 5); chk("R1 recov 4", r_rec, 4);
    chk("R7 doe span", r_doe, 12);
    chk("R3 cmd cs", r_cs, 2'b10); chk("R3 addr 2", r_addr, 3'd2);
    chk("R7 taskfile low byte", r_dout, 16'h00A5);
    run(1'b0, 4'hE, 16'h0, tw(15, 1, 2));
    chk("R1 setup 15", r_su, 15); chk("R1 active 1", r_act, 1); chk("R1 recov 2", r_rec, 2);
    chk("R3 ctl cs", r_cs, 2'b01); chk("R3 addr 6", r_addr, 3'd6);
    chk("R7 read no drive", r_doe, 0);
    run(1'b1, 4'h0, 16'h1234, tw(2, 10, 1));
    chk("R1 setup 2", r_su, 2); chk("R1 active 10", r_act, 10); chk("R1 recov 1", r_rec, 1);
  endtask

  task automatic t_zero();
    run(1'b1, 4'h1, 16'h0, tw(0, 0, 0));
    chk("R2 setup zero", r_su, 1); chk("R2 active zero", r_act, 1); chk("R2 recov zero", r_rec, 1);
    run(1'b0, 4'h1, 16'h0, tw(0, 7, 0));
    chk("R2 mixed setup", r_su, 1); chk("R2 mixed active", r_act, 7); chk("R2 mixed recov", r_rec, 1);
  endtask

  task automatic t_iordy_off();
    ata_iordy = 1'b0; cfg_iordy_en = 1'b0;
    repeat (4) @(negedge clk);
    run(1'b0, 4'h7, 16'h0, tw(1, 4, 1));
    chk("R4 iordy ignored", r_act, 4);
    ata_iordy = 1'b1;
  endtask

  task automatic t_iordy_stretch();
    cfg_iordy_en = 1'b1; ata_iordy = 1'b0;
    repeat (4) @(negedge clk);
    start_req(1'b0, 4'h7, 16'h0, tw(1, 2, 1));
    while (ata_dior_n) @(negedge clk);
    repeat (10) @(negedge clk);
    ata_iordy = 1'b1;
    wait_done();
    chk("R5 stretched active", r_act, 13);
    chk("R5 no timeout", timeout_err, 1'b0);
  endtask

  task automatic t_limit();
    cfg_iordy_en = 1'b1; ata_iordy = 1'b0;
    repeat (4) @(negedge clk);
    run(1'b0, 4'h7, 16'h0, tw(1, 1, 1));
    chk("R6 capped active", r_act, 257);
    chk("R6 error raised", timeout_err, 1'b1);
    ata_iordy = 1'b1;
    repeat (4) @(negedge clk);
    run(1'b0, 4'h7, 16'h0, tw(1, 1, 1));
    chk("R6 error cleared", timeout_err, 1'b0);
    chk("R6 normal active", r_act, 1);
    cfg_iordy_en = 1'b0;
  endtask

  task automatic t_write_fmt();
    cfg_swap = 1'b1;
    run(1'b1, 4'h0, 16'h1234, tw(1, 2, 1));
    chk("R9 write swapped", r_dout, 16'h3412);
    run(1'b1, 4'h5, 16'hABCD, tw(1, 2, 1));
    chk("R9 taskfile unswapped", r_dout, 16'h00CD);
    cfg_swap = 1'b0;
    run(1'b1, 4'h0, 16'h1234, tw(1, 2, 1));
    chk("R7 data reg 16 bit", r_dout, 16'h1234);
  endtask

  task automatic t_read_fmt();
    cfg_swap = 1'b1; ata_din = 16'hBEEF;
    run(1'b0, 4'h0, 16'h0, tw(1, 2, 1));
    chk("R9 read swapped", rd_data, 16'hEFBE);
    cfg_swap = 1'b0;
    run(1'b0, 4'h0, 16'h0, tw(1, 2, 1));
    chk("R8 read data reg", rd_data, 16'hBEEF);
    cfg_swap = 1'b1; ata_din = 16'h5AC3;
    run(1'b0, 4'h3, 16'h0, tw(1, 2, 1));
    chk("R8 taskfile zero ext", rd_data, 16'h00C3);
    ata_din = 16'h0000;
    repeat (5) @(negedge clk);
    chk("R8 read data held", rd_data, 16'h00C3);
    cfg_swap = 1'b0;
  endtask

  task automatic t_enable();
    int bad = 0;
    ctl_enable = 1'b0;
    @(negedge clk);
    timing_word = tw(1, 1, 1); req_write = 1'b1; req_sel = 4'h1; req_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (req_ready || ata_cs_n != 2'b11 || !ata_dior_n || !ata_diow_n || done) bad++;
    end
    chk("R10 idle while disabled", bad, 0);
    ctl_enable = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk("R10 runs once enabled", r_act, 1);
  endtask

  task automatic t_done();
    run(1'b1, 4'h4, 16'h0, tw(2, 3, 2));
    chk("R11 done latency", n_to_done, 8);
    @(negedge clk);
    chk("R11 done one cycle", done, 1'b0);
    chk("R11 ready only when idle", bad_ready, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; ctl_enable = 1'b0; cfg_iordy_en = 1'b0; cfg_swap = 1'b0;
    timing_word = '0; req_valid = 1'b0; req_write = 1'b0; req_sel = '0; req_wdata = '0;
    ata_din = '0; ata_iordy = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    ctl_enable = 1'b1;
    t_timing();
    t_zero();
    t_iordy_off();
    t_iordy_stretch();
    t_limit();
    t_write_fmt();
    t_read_fmt();
    t_enable();
    t_done();
    finish_run();
  end

endmodule